// File: doc/BRIEF.md
# Gap-Coded Transponder Command Sequencer

This block drives the reader field of a low-frequency reader so that a rewritable transponder receives reset, write and read commands. Information reaches the tag as the length of each field-on interval. The intervals are separated by off gaps of fixed length, and every command opens with a long off interval. The block is paced by a tick enable that pulses once per carrier field clock. All durations below are counted in ticks.

A command is launched with a one-cycle `start` pulse while the block is idle. The block latches the command fields and serialises the frame. After a write it keeps the field on long enough for the tag to program its memory. After a read or a reset it keeps the field on for a short settle interval and then raises `acq_window` for a programmable number of ticks, so that a separate sampler can capture the reply. The field is switched off when the command completes.

The state machine has seven states:
- ST_IDLE: field off. `start` moves it to ST_START_GAP.
- ST_START_GAP: field off for 50 ticks, then ST_BIT_ON.
- ST_BIT_ON: field on for the current bit's on time, then ST_BIT_GAP.
- ST_BIT_GAP: field off for 20 ticks. It then goes to ST_BIT_ON for the next bit. After the last bit it goes to ST_PROGRAM for a write, or to ST_SETTLE otherwise.
- ST_SETTLE: field on for 15 ticks. It then goes to ST_ACQUIRE, or to ST_IDLE when the acquire length is zero.
- ST_ACQUIRE: field on with `acq_window` high, then ST_IDLE.
- ST_PROGRAM: field on for 2500 ticks (20 ms), then ST_IDLE.

Top module: `gcs_seq`

## Requirements
- R1: After reset, `field_on`, `acq_window` and `busy` are all low, and they stay low while the block is idle.
- R2: Every command begins with the field off for 50 ticks, starting in the cycle after `start` is sampled.
- R3: Each frame bit is sent as a field-on interval followed by 20 ticks of field off. A 0 is on for 18 ticks; a 1 is on for 54 ticks.
- R4: `cmd_kind` 2'b00 (reset) sends the two bits 0,0 and then follows the read tail of R9.
- R5: `cmd_kind` 2'b01 (write) sends its bits in this order:
  - 1, then `page_sel`;
  - the 32 `password` bits, MSB first, only when `pwd_mode` is 1;
  - a 0;
  - the 32 `wr_data` bits, MSB first;
  - the 3 address bits, MSB first.
- R6: After the last write bit gap, the field stays on for 2500 ticks and then goes off. `acq_window` is never raised for a write.
- R7: `cmd_kind` 2'b10 (read) sends its bits in this order:
  - 1, then `page_sel`;
  - the password, only when `pwd_mode` is 1;
  - a 0;
  - the 3 address bits, MSB first, except when `blk_addr` is 8'hFF (register read), which sends no address bits.
  
  `cmd_kind` 2'b11 behaves as a read.
- R8: Only the low 3 bits of `blk_addr` are sent, so any value other than 8'hFF is taken modulo 8.
- R9: After the last bit gap of a read or reset, the field is on for 15 ticks. Then `acq_window` is high, with the field still on, for `acq_ticks` ticks, after which the field goes off. When `acq_ticks` is 0 there is no window and the field goes off after the 15 ticks.
- R10: All durations are counted in ticks. While `tick` is low and a command is in progress, the outputs do not change.
- R11: A `start` pulse while `busy` is high is ignored. The running command's waveform is unchanged even if the command inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One pulse per field clock; paces all durations |
| start | input | 1 | Launches a command when idle |
| cmd_kind | input | 2 | 00 reset, 01 write, 10 or 11 read |
| page_sel | input | 1 | Page bit sent after the leading 1 |
| blk_addr | input | 8 | Block address; low 3 bits sent; 8'hFF selects register read |
| wr_data | input | 32 | Write data, sent MSB first |
| password | input | 32 | Password, sent MSB first when enabled |
| pwd_mode | input | 1 | Include the password in the frame |
| acq_ticks | input | 16 | Length of the acquire window in ticks |
| field_on | output | 1 | Reader field enable |
| acq_window | output | 1 | High while the reply should be sampled |
| busy | output | 1 | High while a command is in progress |

## Verification
The bench records the field waveform as a list of on and off run lengths. It compares that list against a list built from the frame rules in the requirements.

Writes are tried with and without a password, on both pages, with mixed data patterns. This separates the frame ordering and the on lengths for 0 and 1 bits from the programming tail.

Reads are tried with:
- a direct address;
- the register-read address;
- an address above 7;
- the spare command code;
- a zero-length acquire window.

Together these show whether address bits are sent, whether the address is masked, and where the window sits relative to the settle interval. A reset command run at half tick rate shows that every interval scales with the tick. A start pulse injected in the middle of a write, with the command inputs changed, shows that a running command cannot be disturbed.

// File: rtl/gcs_pkg.sv
package gcs_pkg;

    localparam int WORD_W     = 32;
    localparam int ADDR_BITS  = 3;
    localparam int ADDR_IN_W  = 8;
    localparam logic [ADDR_IN_W-1:0] REG_READ_ADDR = 8'hFF;
    // opcode (2) + password + separator + data + address
    localparam int FRAME_MAX  = 2 + WORD_W + 1 + WORD_W + ADDR_BITS;
    localparam int LEN_W      = $clog2(FRAME_MAX + 1);

    typedef enum logic [1:0] {
        CMD_RESET    = 2'b00,
        CMD_WRITE    = 2'b01,
        CMD_READ     = 2'b10,
        CMD_READ_ALT = 2'b11
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START_GAP,
        ST_BIT_ON,
        ST_BIT_GAP,
        ST_SETTLE,
        ST_ACQUIRE,
        ST_PROGRAM
    } state_e;

endpackage

// File: rtl/gcs_framer.sv
module gcs_framer
    import gcs_pkg::*;
(
    input  cmd_e                   cmd_kind,
    input  logic                   page_sel,
    input  logic [ADDR_IN_W-1:0]   blk_addr,
    input  logic [WORD_W-1:0]      wr_data,
    input  logic [WORD_W-1:0]      password,
    input  logic                   pwd_mode,
    output logic [FRAME_MAX-1:0]   frame,
    output logic [LEN_W-1:0]       frame_len
);

    logic [FRAME_MAX-1:0] acc;
    logic [LEN_W-1:0]     n;
    logic [ADDR_BITS-1:0] addr_bits;
    logic                 reg_read;

    assign addr_bits = blk_addr[ADDR_BITS-1:0];
    assign reg_read  = (blk_addr == REG_READ_ADDR);

    // Accumulate bits right-aligned, then left-align so the first bit is the MSB.
    always_comb begin
        acc = '0;
        n   = '0;
        if (cmd_kind == CMD_RESET) begin
            n = LEN_W'(2);
        end else begin
            acc = FRAME_MAX'({1'b1, page_sel});
            n   = LEN_W'(2);
            if (pwd_mode) begin
                acc = (acc << WORD_W) | FRAME_MAX'(password);
                n   = n + LEN_W'(WORD_W);
            end
            acc = acc << 1;
            n   = n + LEN_W'(1);
            if (cmd_kind == CMD_WRITE) begin
                acc = (acc << WORD_W) | FRAME_MAX'(wr_data);
                n   = n + LEN_W'(WORD_W);
                acc = (acc << ADDR_BITS) | FRAME_MAX'(addr_bits);
                n   = n + LEN_W'(ADDR_BITS);
            end else if (!reg_read) begin
                acc = (acc << ADDR_BITS) | FRAME_MAX'(addr_bits);
                n   = n + LEN_W'(ADDR_BITS);
            end
        end
    end

    assign frame     = acc << (LEN_W'(FRAME_MAX) - n);
    assign frame_len = n;

endmodule

// File: rtl/gcs_bitq.sv
module gcs_bitq
    import gcs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 shift,
    input  logic [FRAME_MAX-1:0] frame_in,
    input  logic [LEN_W-1:0]     len_in,
    output logic                 cur_bit,
    output logic                 next_bit,
    output logic                 last_bit
);

    logic [FRAME_MAX-1:0] sr_q;
    logic [LEN_W-1:0]     remain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q     <= '0;
            remain_q <= '0;
        end else if (load) begin
            sr_q     <= frame_in;
            remain_q <= len_in;
        end else if (shift) begin
            sr_q     <= sr_q << 1;
            remain_q <= remain_q - LEN_W'(1);
        end
    end

    assign cur_bit  = sr_q[FRAME_MAX-1];
    assign next_bit = sr_q[FRAME_MAX-2];
    assign last_bit = (remain_q == LEN_W'(1));

endmodule

// File: rtl/gcs_interval.sv
module gcs_interval #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // A load of N-1 makes the interval last exactly N ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = tick && (cnt_q == '0);

endmodule

// File: rtl/gcs_seq.sv
module gcs_seq
    import gcs_pkg::*;
#(
    parameter int START_TICKS   = 50,
    parameter int ZERO_ON_TICKS = 18,
    parameter int ONE_ON_TICKS  = 54,
    parameter int GAP_TICKS     = 20,
    parameter int SETTLE_TICKS  = 15,
    parameter int PROGRAM_TICKS = 2500,
    parameter int ACQ_W         = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 start,
    input  logic [1:0]           cmd_kind,
    input  logic                 page_sel,
    input  logic [ADDR_IN_W-1:0] blk_addr,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic [WORD_W-1:0]    password,
    input  logic                 pwd_mode,
    input  logic [ACQ_W-1:0]     acq_ticks,
    output logic                 field_on,
    output logic                 acq_window,
    output logic                 busy
);

    localparam int PROG_W = $clog2(PROGRAM_TICKS + 1);
    localparam int CNT_W  = (ACQ_W > PROG_W) ? ACQ_W : PROG_W;

    state_e               state_q, state_d;
    cmd_e                 cmd_q;
    logic [ACQ_W-1:0]     acq_q;
    logic                 tmr_load;
    logic [CNT_W-1:0]     tmr_val;
    logic                 expired;
    logic                 q_load, q_shift;
    logic                 cur_bit, next_bit, last_bit;
    logic [FRAME_MAX-1:0] frame;
    logic [LEN_W-1:0]     frame_len;

    function automatic logic [CNT_W-1:0] on_len(input logic b);
        return b ? CNT_W'(ONE_ON_TICKS - 1) : CNT_W'(ZERO_ON_TICKS - 1);
    endfunction

    gcs_framer u_framer (
        .cmd_kind  (cmd_e'(cmd_kind)),
        .page_sel  (page_sel),
        .blk_addr  (blk_addr),
        .wr_data   (wr_data),
        .password  (password),
        .pwd_mode  (pwd_mode),
        .frame     (frame),
        .frame_len (frame_len)
    );

    gcs_bitq u_bitq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (q_load),
        .shift    (q_shift),
        .frame_in (frame),
        .len_in   (frame_len),
        .cur_bit  (cur_bit),
        .next_bit (next_bit),
        .last_bit (last_bit)
    );

    gcs_interval #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (expired)
    );

    // State register and command latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cmd_q   <= CMD_RESET;
            acq_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                cmd_q <= cmd_e'(cmd_kind);
                acq_q <= acq_ticks;
            end
        end
    end

    // Next state, timer loads and bit queue control.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        q_load   = 1'b0;
        q_shift  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d  = ST_START_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(START_TICKS - 1);
                    q_load   = 1'b1;
                end
            end
            ST_START_GAP: begin
                if (expired) begin
                    state_d  = ST_BIT_ON;
                    tmr_load = 1'b1;
                    tmr_val  = on_len(cur_bit);
                end
            end
            ST_BIT_ON: begin
                if (expired) begin
                    state_d  = ST_BIT_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(GAP_TICKS - 1);
                end
            end
            ST_BIT_GAP: begin
                if (expired) begin
                    tmr_load = 1'b1;
                    if (!last_bit) begin
                        state_d = ST_BIT_ON;
                        q_shift = 1'b1;
                        tmr_val = on_len(next_bit);
                    end else if (cmd_q == CMD_WRITE) begin
                        state_d = ST_PROGRAM;
                        tmr_val = CNT_W'(PROGRAM_TICKS - 1);
                    end else begin
                        state_d = ST_SETTLE;
                        tmr_val = CNT_W'(SETTLE_TICKS - 1);
                    end
                end
            end
            ST_SETTLE: begin
                if (expired) begin
                    if (acq_q == '0) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d  = ST_ACQUIRE;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(acq_q) - 1'b1;
                    end
                end
            end
            ST_ACQUIRE: begin
                if (expired) state_d = ST_IDLE;
            end
            ST_PROGRAM: begin
                if (expired) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Moore outputs.
    always_comb begin
        field_on   = 1'b0;
        acq_window = 1'b0;
        busy       = (state_q != ST_IDLE);
        unique case (state_q)
            ST_BIT_ON, ST_SETTLE, ST_PROGRAM: field_on = 1'b1;
            ST_ACQUIRE: begin
                field_on   = 1'b1;
                acq_window = 1'b1;
            end
            default: field_on = 1'b0;
        endcase
    end

endmodule

// File: rtl/gcs_seq_chk.sv
module gcs_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic field_on,
    input logic acq_window,
    input logic busy
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!field_on && !acq_window));

    // R2
    start_gap_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !field_on);

    // R9
    acq_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acq_window |-> field_on);

    // R9
    acq_after_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acq_window) |-> $past(field_on));

    // R10
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> ($stable(field_on) && $stable(acq_window) && $stable(busy)));

endmodule

bind gcs_seq gcs_seq_chk u_gcs_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .field_on   (field_on),
    .acq_window (acq_window),
    .busy       (busy)
);

// File: tb/gcs_seq_test.sv
module gcs_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  cmd_kind = 2'b00;
    logic        page_sel = 1'b0;
    logic [7:0]  blk_addr = 8'h00;
    logic [31:0] wr_data = '0;
    logic [31:0] password = '0;
    logic        pwd_mode = 1'b0;
    logic [15:0] acq_ticks = '0;
    logic        field_on, acq_window, busy;
    logic        slow_tick = 1'b0;

    int checks = 0;
    int errors = 0;

    // expected frame bits and run list
    bit eb [0:127];
    int en;
    bit xv [0:255];
    int xl [0:255];
    int xn;
    // captured run list
    bit gv [0:255];
    int gl [0:255];
    int gn;
    int acq_first, acq_cnt;

    always #10 clk = ~clk;

    always @(negedge clk) tick <= slow_tick ? ~tick : 1'b1;

    gcs_seq uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
        .cmd_kind(cmd_kind), .page_sel(page_sel), .blk_addr(blk_addr),
        .wr_data(wr_data), .password(password), .pwd_mode(pwd_mode),
        .acq_ticks(acq_ticks), .field_on(field_on), .acq_window(acq_window),
        .busy(busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic build_bits(input logic [1:0] k, input logic pg, input logic [7:0] ad,
                              input logic [31:0] d, input logic [31:0] pw, input logic pm);
        en = 0;
        if (k == 2'b00) begin
            eb[0] = 0; eb[1] = 0; en = 2;
        end else begin
            eb[en] = 1; en++;
            eb[en] = pg; en++;
            if (pm) for (int i = 31; i >= 0; i--) begin eb[en] = pw[i]; en++; end
            eb[en] = 0; en++;
            if (k == 2'b01) begin
                for (int i = 31; i >= 0; i--) begin eb[en] = d[i]; en++; end
                for (int i = 2; i >= 0; i--) begin eb[en] = ad[i]; en++; end
            end else if (ad != 8'hFF) begin
                for (int i = 2; i >= 0; i--) begin eb[en] = ad[i]; en++; end
            end
        end
    endtask

    task automatic add_run(input bit v, input int len);
        if (xn > 0 && xv[xn-1] == v) xl[xn-1] += len;
        else begin xv[xn] = v; xl[xn] = len; xn++; end
    endtask

    task automatic build_runs(input logic [1:0] k, input int acq, input int s);
        xn = 0;
        add_run(0, 50 * s);
        for (int i = 0; i < en; i++) begin
            add_run(1, (eb[i] ? 54 : 18) * s);
            add_run(0, 20 * s);
        end
        if (k == 2'b01) add_run(1, 2500 * s);
        else            add_run(1, (15 + acq) * s);
    endtask

    task automatic capture(input bit inject);
        int cyc;
        gn = 0; acq_first = -1; acq_cnt = 0; cyc = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (busy && cyc < 30000) begin
            if (gn > 0 && gv[gn-1] == field_on) gl[gn-1]++;
            else begin gv[gn] = field_on; gl[gn] = 1; gn++; end
            if (acq_window) begin
                if (acq_first < 0) acq_first = cyc;
                acq_cnt++;
            end
            if (inject && cyc == 120) begin
                start = 1'b1; cmd_kind = 2'b00; wr_data = ~wr_data;
            end else begin
                start = 1'b0;
            end
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        check(cyc < 30000, "R2", "command did not finish, cycles", cyc, 30000);
    endtask

    task automatic compare(input string req, input int skip);
        int mism = -1;
        check(gn == xn, req, "run count", gn, xn);
        for (int i = skip; i < gn && i < xn; i++)
            if (mism < 0 && (gl[i] != xl[i] || gv[i] != xv[i])) mism = i;
        if (mism >= 0) check(0, req, "run length (level in msg bit) at mismatching run", gl[mism], xl[mism]);
        else check(1, req, "runs", 0, 0);
        check(field_on == 1'b0 && acq_window == 1'b0, "R1", "outputs after completion", field_on, 0);
    endtask

    task automatic acq_check(input string req, input int acq, input int s);
        int tail_start = 0;
        for (int i = 0; i < gn - 1; i++) tail_start += gl[i];
        check(acq_cnt == acq * s, req, "acquire window length", acq_cnt, acq * s);
        if (acq > 0)
            check(acq_first == tail_start + 15 * s, req, "acquire window start", acq_first, tail_start + 15 * s);
    endtask

    task automatic setup(input logic [1:0] k, input logic pg, input logic [7:0] ad,
                         input logic [31:0] d, input logic [31:0] pw, input logic pm,
                         input logic [15:0] acq);
        cmd_kind = k; page_sel = pg; blk_addr = ad; wr_data = d;
        password = pw; pwd_mode = pm; acq_ticks = acq;
    endtask

    task automatic t_reset_state;
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        check(field_on == 1'b0, "R1", "field_on after reset", field_on, 0);
        check(acq_window == 1'b0, "R1", "acq_window after reset", acq_window, 0);
    endtask

    task automatic t_reset_cmd;
        setup(2'b00, 1'b1, 8'h03, 32'h0, 32'h0, 1'b0, 16'd12);
        build_bits(2'b00, 1'b1, 8'h03, 32'h0, 32'h0, 1'b0);
        build_runs(2'b00, 12, 1);
        capture(0);
        compare("R4", 0);
        acq_check("R9", 12, 1);
    endtask

    task automatic t_write_plain;
        setup(2'b01, 1'b0, 8'h05, 32'hA5F00F3C, 32'h0, 1'b0, 16'd9);
        build_bits(2'b01, 1'b0, 8'h05, 32'hA5F00F3C, 32'h0, 1'b0);
        build_runs(2'b01, 0, 1);
        capture(0);
        compare("R3 R5", 0);
        check(gv[0] == 0 && gl[0] == 50, "R2", "start gap length", gl[0], 50);
        check(gl[gn-1] == 2500 && gv[gn-1] == 1, "R6", "program interval", gl[gn-1], 2500);
        check(acq_cnt == 0, "R6", "acquire window after write", acq_cnt, 0);
    endtask

    task automatic t_write_pwd_busy;
        setup(2'b01, 1'b1, 8'h03, 32'hFFFF0001, 32'h13579BDF, 1'b1, 16'd0);
        build_bits(2'b01, 1'b1, 8'h03, 32'hFFFF0001, 32'h13579BDF, 1'b1);
        build_runs(2'b01, 0, 1);
        capture(1);
        compare("R5 R11", 0);
    endtask

    task automatic t_read_direct;
        setup(2'b10, 1'b0, 8'h07, 32'h0, 32'h0, 1'b0, 16'd30);
        build_bits(2'b10, 1'b0, 8'h07, 32'h0, 32'h0, 1'b0);
        build_runs(2'b10, 30, 1);
        capture(0);
        compare("R7", 0);
        acq_check("R9", 30, 1);
        setup(2'b11, 1'b1, 8'h01, 32'h0, 32'h0, 1'b0, 16'd3);
        build_bits(2'b11, 1'b1, 8'h01, 32'h0, 32'h0, 1'b0);
        build_runs(2'b11, 3, 1);
        capture(0);
        compare("R7", 0);
    endtask

    task automatic t_reg_read;
        setup(2'b10, 1'b1, 8'hFF, 32'h0, 32'hC0DE1234, 1'b1, 16'd5);
        build_bits(2'b10, 1'b1, 8'hFF, 32'h0, 32'hC0DE1234, 1'b1);
        build_runs(2'b10, 5, 1);
        capture(0);
        compare("R7", 0);
    endtask

    task automatic t_addr_mask;
        setup(2'b10, 1'b0, 8'h0D, 32'h0, 32'h0, 1'b0, 16'd4);
        build_bits(2'b10, 1'b0, 8'h05, 32'h0, 32'h0, 1'b0);
        build_runs(2'b10, 4, 1);
        capture(0);
        compare("R8", 0);
    endtask

    task automatic t_acq_zero;
        setup(2'b10, 1'b0, 8'h02, 32'h0, 32'h0, 1'b0, 16'd0);
        build_bits(2'b10, 1'b0, 8'h02, 32'h0, 32'h0, 1'b0);
        build_runs(2'b10, 0, 1);
        capture(0);
        compare("R9", 0);
        check(acq_cnt == 0, "R9", "window with zero length", acq_cnt, 0);
    endtask

    task automatic t_slow_tick;
        slow_tick = 1'b1;
        setup(2'b00, 1'b0, 8'h00, 32'h0, 32'h0, 1'b0, 16'd4);
        build_bits(2'b00, 1'b0, 8'h00, 32'h0, 32'h0, 1'b0);
        build_runs(2'b00, 4, 2);
        capture(0);
        compare("R10", 1);
        acq_check("R10", 4, 2);
        slow_tick = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_reset_cmd();
        t_write_plain();
        t_write_pwd_busy();
        t_read_direct();
        t_reg_read();
        t_addr_mask();
        t_acq_zero();
        t_slow_tick();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog expired: actual %0d expected %0d", 200000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule